// File: doc/BRIEF.md
# Idle Sleep-Depth Selector

This block sits beside a processor core and decides how deeply the core may sleep when it goes idle. When an idle request arrives, the block compares a predicted idle length, given in microsecond ticks, with the wake cost of each sleep depth. It then picks the deepest depth whose wake cost is repaid by the expected rest. If no deeper depth qualifies, it uses the lightest clock-gated depth.

After choosing a depth, the block enters it one step per clock. Each step turns on one more power-saving action: clock gating, voltage reduction, cache flush, core power-off and package power-off. A wake event switches every action off and loads a counter with the wake latency of the depth the core reached. The ready flag returns only when that counter has expired. A wake event that arrives while the entry steps are still running cuts the entry short, and the exit starts at once.

The prediction, the flush data path and the power rails are outside this block. Each is represented only by a control level and the latency timer.

Top module: `idle_depth_sel`

## Requirements
- R1: After reset the block reports depth code 0 (running). Ready is 1 and all five control outputs are 0.
- R2: Wake latencies in ticks are 1 for depth 1, 4 for depth 2, 30 for depth 3, 80 for depth 4 and 300 for depth 5. On an accepted idle request the target depth is the deepest of depths 2 to 5 whose latency times 3 does not exceed the prediction. If none qualifies, the target is depth 1.
- R3: A prediction below 240 never selects depth 4 or 5. A prediction below 12 always selects depth 1. For example, a prediction of 5 selects depth 1.
- R4: After the clock edge that accepts the idle request, the depth code is 1. It rises by one on each following edge until it equals the target, and it then holds for as long as the core sleeps.
- R5: The control bits are cumulative while the block is entering or sleeping. clk_gate is on at depth 1 and above, volt_low at depth 2 and above, cache_flush at depth 3 and above, core_off at depth 4 and above, and pkg_off at depth 5.
- R6: A wake event seen while sleeping starts the exit. From the next cycle, ready is 0 and all controls are 0, while the depth code holds the depth being left. Ready returns exactly L clock edges after the edge that sampled the wake event, where L is the R2 latency of that depth. At that point the depth code returns to 0.
- R7: A wake event seen during entry aborts the entry straight away. The exit then uses the latency of the depth reached so far, following the same timing as R6.
- R8: A wake event while running has no effect. An idle request during the exit has no effect, and the core returns to running once the latency has expired.
- R9: The depth code is 3 bits wide, 0 for running and 1 to 5 from shallowest to deepest, and it never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Request to go idle, accepted only while running |
| pred_len | input | PRED_W (16) | Predicted idle length in ticks, sampled with idle_req |
| wake | input | 1 | Wake event |
| depth_code | output | 3 | Current depth, 0 running to 5 deepest |
| clk_gate | output | 1 | Clock-gate control |
| volt_low | output | 1 | Voltage-reduce control |
| cache_flush | output | 1 | Cache-flush control |
| core_off | output | 1 | Core power-off control |
| pkg_off | output | 1 | Package power-off control |
| ready | output | 1 | Core running and usable |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that wake and idle_req can arrive in any phase, because the block must ignore or absorb them depending on where it is. The bench drives every input on the falling edge and samples on the falling edge. It raises wake in each phase: while running, part-way through entry and while sleeping. It raises idle_req during an exit. The predictions straddle each selection threshold by one tick, and one case uses the largest value a 16-bit prediction can hold.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int DEPTH_W = 3;
  localparam int NUM_ACT = 5;

  typedef enum logic [1:0] {PH_RUN, PH_ENTER, PH_SLEEP, PH_EXIT} phase_t;

  // wake cost in ticks of each sleep depth (0 = running)
  function automatic int unsigned wake_lat(input logic [DEPTH_W-1:0] d);
    case (d)
      3'd1:    return 1;
      3'd2:    return 4;
      3'd3:    return 30;
      3'd4:    return 80;
      3'd5:    return 300;
      default: return 0;
    endcase
  endfunction

  // deepest depth whose cost times margin fits the prediction, else depth 1
  function automatic logic [DEPTH_W-1:0] pick_depth(input logic [31:0] pred,
                                                    input int unsigned margin);
    logic [DEPTH_W-1:0] best;
    best = 3'd1;
    for (int d = 2; d <= NUM_ACT; d++) begin
      if (wake_lat(DEPTH_W'(d)) * margin <= pred) best = DEPTH_W'(d);
    end
    return best;
  endfunction
endpackage

// File: rtl/depth_pick.sv
module depth_pick #(
  parameter int PRED_W = 16,
  parameter int MARGIN = 3
) (
  input  logic [PRED_W-1:0]            pred,
  output logic [idle_pkg::DEPTH_W-1:0] depth
);
  always_comb depth = idle_pkg::pick_depth(32'(pred), MARGIN);
endmodule

// File: rtl/exit_timer.sv
module exit_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last_tick
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last_tick = (cnt == CNT_W'(1));
endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode #(
  parameter int NUM_ACT = idle_pkg::NUM_ACT
) (
  input  logic                         active,
  input  logic [idle_pkg::DEPTH_W-1:0] level,
  output logic [NUM_ACT-1:0]           acts
);
  for (genvar i = 0; i < NUM_ACT; i++) begin : g_act
    assign acts[i] = active && (level > idle_pkg::DEPTH_W'(i));
  end
endmodule

// File: rtl/idle_depth_sel.sv
module idle_depth_sel #(
  parameter int PRED_W = 16,
  parameter int MARGIN = 3,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic [PRED_W-1:0] pred_len,
  input  logic              wake,
  output logic [2:0]        depth_code,
  output logic              clk_gate,
  output logic              volt_low,
  output logic              cache_flush,
  output logic              core_off,
  output logic              pkg_off,
  output logic              ready
);
  import idle_pkg::*;

  phase_t               phase;
  logic [DEPTH_W-1:0]   level;
  logic [DEPTH_W-1:0]   target;
  logic [DEPTH_W-1:0]   picked;
  logic [NUM_ACT-1:0]   acts;

  // named events used by the checker
  logic in_enter, in_sleep, in_exit, exit_fin, exit_load;
  logic [CNT_W-1:0] exit_len;

  assign in_enter  = (phase == PH_ENTER);
  assign in_sleep  = (phase == PH_SLEEP);
  assign in_exit   = (phase == PH_EXIT);
  assign exit_load = wake && (in_enter || in_sleep);
  assign exit_len  = CNT_W'(wake_lat(level));

  depth_pick #(.PRED_W(PRED_W), .MARGIN(MARGIN)) pick_i (
    .pred  (pred_len),
    .depth (picked)
  );

  exit_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (exit_load),
    .load_val  (exit_len),
    .last_tick (exit_fin)
  );

  ctrl_decode #(.NUM_ACT(NUM_ACT)) dec_i (
    .active (in_enter || in_sleep),
    .level  (level),
    .acts   (acts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_RUN;
      level  <= '0;
      target <= '0;
    end else begin
      case (phase)
        PH_RUN: if (idle_req) begin
          target <= picked;
          level  <= DEPTH_W'(1);
          phase  <= PH_ENTER;
        end
        PH_ENTER: begin
          if (wake)                 phase <= PH_EXIT;
          else if (level == target) phase <= PH_SLEEP;
          else                      level <= level + 1'b1;
        end
        PH_SLEEP: if (wake) phase <= PH_EXIT;
        PH_EXIT: if (exit_fin) begin
          phase <= PH_RUN;
          level <= '0;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign depth_code  = level;
  assign ready       = (phase == PH_RUN);
  assign clk_gate    = acts[0];
  assign volt_low    = acts[1];
  assign cache_flush = acts[2];
  assign core_off    = acts[3];
  assign pkg_off     = acts[4];
endmodule

// File: rtl/idle_depth_sel_chk.sv
module idle_depth_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wake,
  input logic [2:0] depth_code,
  input logic       clk_gate,
  input logic       volt_low,
  input logic       cache_flush,
  input logic       core_off,
  input logic       pkg_off,
  input logic       ready,
  input logic       in_enter,
  input logic       in_sleep,
  input logic       in_exit,
  input logic       exit_fin
);
  a_r1_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (depth_code == 3'd0) && !clk_gate && !pkg_off);

  a_r5_nested: assert property (@(posedge clk) disable iff (!rst_n)
    (!volt_low || clk_gate) && (!cache_flush || volt_low) &&
    (!core_off || cache_flush) && (!pkg_off || core_off));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_enter && !wake) |=>
      (in_sleep && $stable(depth_code)) ||
      (in_enter && depth_code == $past(depth_code) + 3'd1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && !wake) |=> in_sleep && $stable(depth_code));

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (in_enter && wake) |=> in_exit && $stable(depth_code));

  a_r6_dark_exit: assert property (@(posedge clk) disable iff (!rst_n)
    in_exit |-> !clk_gate && !ready);

  a_r6_ready_timed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(exit_fin));

  a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
    depth_code <= 3'd5);
endmodule

bind idle_depth_sel idle_depth_sel_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wake        (wake),
  .depth_code  (depth_code),
  .clk_gate    (clk_gate),
  .volt_low    (volt_low),
  .cache_flush (cache_flush),
  .core_off    (core_off),
  .pkg_off     (pkg_off),
  .ready       (ready),
  .in_enter    (in_enter),
  .in_sleep    (in_sleep),
  .in_exit     (in_exit),
  .exit_fin    (exit_fin)
);

// File: tb/idle_depth_sel_tb.sv
module idle_depth_sel_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, idle_req, wake;
  logic [15:0] pred_len;
  logic [2:0] depth_code;
  logic clk_gate, volt_low, cache_flush, core_off, pkg_off, ready;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  idle_depth_sel dut_i (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pred_len(pred_len),
    .wake(wake), .depth_code(depth_code), .clk_gate(clk_gate),
    .volt_low(volt_low), .cache_flush(cache_flush), .core_off(core_off),
    .pkg_off(pkg_off), .ready(ready)
  );

  function automatic int cost(input int d);
    int t [6] = '{0, 1, 4, 30, 80, 300};
    return t[d];
  endfunction

  function automatic int want_depth(input int p);
    int r = 1;
    for (int d = 5; d >= 2; d--) if (r == 1 && 3 * cost(d) <= p) r = d;
    return r;
  endfunction

  function automatic logic [4:0] ctl_mask(input int d);
    return 5'((1 << d) - 1);
  endfunction

  function automatic logic [4:0] ctl();
    return {pkg_off, core_off, cache_flush, volt_low, clk_gate};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // counts edges until ready returns, from just after the wake edge
  task automatic time_exit(input int d, input string tag);
    int n = 0;
    check(ready == 0, {tag, " ready low in exit"}, ready, 0);
    check(ctl() == 5'd0, {tag, " controls off in exit"}, ctl(), 0);
    check(depth_code == 3'(d), {tag, " depth held in exit"}, depth_code, d);
    while (!ready && n < 1000) begin n++; tick(); end
    check(n == cost(d), {tag, " exit latency"}, n, cost(d));
    check(depth_code == 3'd0, {tag, " depth back to 0"}, depth_code, 0);
  endtask

  task automatic t_reset();
    check(ready == 1, "R1 ready", ready, 1);
    check(depth_code == 3'd0, "R1 depth", depth_code, 0);
    check(ctl() == 5'd0, "R1 controls", ctl(), 0);
  endtask

  task automatic t_sleep(input int p);
    int d = want_depth(p);
    pred_len = 16'(p); idle_req = 1; tick(); idle_req = 0;
    for (int k = 1; k <= d; k++) begin
      check(depth_code == 3'(k), "R4 entry step", depth_code, k);
      check(ctl() == ctl_mask(k), "R5 entry controls", ctl(), ctl_mask(k));
      tick();
    end
    tick();
    check(depth_code == 3'(d), "R2 selected depth", depth_code, d);
    if (p < 240) check(depth_code < 3'd4, "R3 short never deep", depth_code, d);
    check(ctl() == ctl_mask(d), "R5 sleep controls", ctl(), ctl_mask(d));
    check(depth_code <= 3'd5, "R9 code range", depth_code, d);
    wake = 1; tick(); wake = 0;
    time_exit(d, "R6");
  endtask

  task automatic t_abort(input int p, input int steps);
    pred_len = 16'(p); idle_req = 1; tick(); idle_req = 0;
    for (int k = 1; k < steps; k++) tick();
    check(depth_code == 3'(steps), "R7 depth before abort", depth_code, steps);
    wake = 1; tick(); wake = 0;
    time_exit(steps, "R7");
  endtask

  task automatic t_ignore();
    wake = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check(ready == 1 && depth_code == 3'd0, "R8 wake while running", depth_code, 0);
    end
    wake = 0;
    pred_len = 16'd100; idle_req = 1; tick(); idle_req = 0;
    tick(); tick(); tick(); tick();
    wake = 1; tick(); wake = 0;
    idle_req = 1; tick(); idle_req = 0;
    check(ready == 0 && ctl() == 5'd0, "R8 idle during exit", ctl(), 0);
    for (int k = 0; k < 40; k++) tick();
    check(ready == 1 && depth_code == 3'd0, "R8 back to running", depth_code, 0);
  endtask

  task automatic finish_all();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_all();
  end

  initial begin
    rst_n = 0; idle_req = 0; wake = 0; pred_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sleep(0);
    t_sleep(5);
    t_sleep(11);
    t_sleep(12);
    t_sleep(89);
    t_sleep(90);
    t_sleep(239);
    t_sleep(240);
    t_sleep(899);
    t_sleep(900);
    t_sleep(65535);
    t_abort(900, 2);
    t_abort(900, 4);
    t_abort(90, 1);
    t_ignore();
    finish_all();
  end
endmodule